// File: doc/BRIEF.md
# Serial Buffer DMA Request Generator

This block holds the two-entry transmit and receive buffers of a serial port and turns their fill levels into DMA request lines. Each direction drives one single-transfer request and one burst request toward the DMA controller, and each has its own acknowledge. A use-bursts control input picks the behaviour. When it is low, a request is raised whenever one entry can move. When it is high, the block stays quiet until both entries can move at once.

A bus port reads and writes the buffers. A normal access moves one entry, carried in the low half of the word. A dual access moves both entries as one word: the older entry (entry 0) sits in the low half and entry 1 in the high half. The shifter side pops transmit entries and pushes receive entries. Misuse from either side sets sticky error flags, which the interrupt logic reads.

Top module: `sbd_dma_req`

## Requirements
- R1: With use_bursts_i low, tx_single_o is high exactly when the transmit level is below 2, and tx_burst_o stays low.
- R2: With use_bursts_i low, rx_single_o is high exactly when the receive level is above 0, and rx_burst_o stays low.
- R3: With use_bursts_i high, tx_burst_o is high exactly when the transmit level is 0, and tx_single_o stays low.
- R4: With use_bursts_i high, rx_burst_o is high exactly when the receive level is 2, and rx_single_o stays low.
- R5: An acknowledge that arrives while a direction is requesting forces both of that direction's requests low from the next cycle on. They stay low until the level differs from the level seen in the acknowledge cycle. From the cycle after that difference, the requests follow R1 to R4 again.
- R6: A dual write (bus_we_i and bus_dual_i) to an empty transmit buffer loads both entries. Bits [DW-1:0] become entry 0, which is sent first, and the upper half becomes entry 1.
- R7: A dual write to a transmit buffer that holds any entry, or a single write to a full transmit buffer, is rejected. The buffer is left unchanged and err_tx_ovf_o is set.
- R8: A dual read while the receive level is 2 returns {entry 1, entry 0} on bus_rdata_o in the same cycle and empties the buffer. A dual read at a lower level returns 0 and changes nothing.
- R9: A single read returns the oldest receive entry, zero-extended, and removes it. On an empty buffer it returns 0.
- R10: A shifter pop on an empty transmit buffer sets err_tx_udf_o, which then stays set until reset.
- R11: A shifter push into a full receive buffer is dropped and sets err_rx_ovf_o, which then stays set until reset. The stored entries are unchanged.
- R12: Transmit and receive requests are computed independently and can be high at the same time.
- R13: Both buffers are first-in first-out, and their levels never exceed 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| use_bursts_i | input | 1 | 1 = burst requests only, 0 = single requests only |
| bus_we_i | input | 1 | Bus write to the transmit buffer |
| bus_re_i | input | 1 | Bus read from the receive buffer |
| bus_dual_i | input | 1 | Access moves both entries as one word |
| bus_wdata_i | input | 2*DW | Write data |
| bus_rdata_o | output | 2*DW | Read data, valid in the cycle of bus_re_i |
| shf_tx_pop_i | input | 1 | Shifter takes the oldest transmit entry |
| shf_tx_data_o | output | DW | Oldest transmit entry |
| shf_rx_push_i | input | 1 | Shifter delivers a received entry |
| shf_rx_data_i | input | DW | Received entry |
| tx_level_o | output | 2 | Transmit occupancy |
| rx_level_o | output | 2 | Receive occupancy |
| tx_single_o | output | 1 | Transmit single request |
| tx_burst_o | output | 1 | Transmit burst request |
| tx_ack_i | input | 1 | Transmit request acknowledge |
| rx_single_o | output | 1 | Receive single request |
| rx_burst_o | output | 1 | Receive burst request |
| rx_ack_i | input | 1 | Receive request acknowledge |
| err_tx_udf_o | output | 1 | Sticky transmit underflow |
| err_tx_ovf_o | output | 1 | Sticky transmit overflow |
| err_rx_ovf_o | output | 1 | Sticky receive overflow |

## Verification
The bench builds the block with DW = 4, so a combined word is 8 bits wide. This small width lets every one of the 256 combined words go through a dual write followed by two shifter pops, and every one go through two shifter pushes followed by a dual read. Both packing halves and the first-in first-out order are therefore checked for every value. Also within reach is a full sweep of both modes against all nine pairs of transmit and receive levels, which checks all four request lines. Directed runs cover the acknowledge hold-off, rejected accesses and the sticky flags.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned ENTRIES = 2;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_EMPTY = 2'd0;
  localparam lvl_t LVL_FULL  = 2'd2;
  typedef struct packed {
    logic single;
    logic burst;
  } req_t;
endpackage

// File: rtl/sbd_pair_fifo.sv
module sbd_pair_fifo
  import sbd_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned BW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    push_n_i,
  input  logic [BW-1:0] din_i,
  input  logic [1:0]    pop_n_i,
  output lvl_t          level_o,
  output logic [BW-1:0] dout_o
);
  logic [DW-1:0] ent_q [ENTRIES];
  logic [DW-1:0] ent_d [ENTRIES];
  lvl_t lvl_q, lvl_d;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_q[i];
    lvl_d = lvl_q;
    unique case (pop_n_i)
      2'd1: begin
        ent_d[0] = ent_q[1];
        lvl_d    = lvl_q - 2'd1;
      end
      2'd2:    lvl_d = LVL_EMPTY;
      default: ;
    endcase
    unique case (push_n_i)
      2'd1: begin
        ent_d[lvl_d[0]] = din_i[DW-1:0];
        lvl_d           = lvl_d + 2'd1;
      end
      2'd2: begin
        ent_d[0] = din_i[DW-1:0];
        ent_d[1] = din_i[BW-1:DW];
        lvl_d    = LVL_FULL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_EMPTY;
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      lvl_q <= lvl_d;
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign level_o = lvl_q;
  assign dout_o  = {ent_q[1], ent_q[0]};

  assert_level_bound_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_FULL);
endmodule

// File: rtl/sbd_req_gen.sv
module sbd_req_gen
  import sbd_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic use_bursts_i,
  input  lvl_t level_i,
  input  logic ack_i,
  output req_t req_o
);
  logic want_single, want_burst, blk_q;
  lvl_t snap_q;

  generate
    if (IS_TX) begin : g_tx
      assign want_single = !use_bursts_i && (level_i != LVL_FULL);
      assign want_burst  =  use_bursts_i && (level_i == LVL_EMPTY);
    end else begin : g_rx
      assign want_single = !use_bursts_i && (level_i != LVL_EMPTY);
      assign want_burst  =  use_bursts_i && (level_i == LVL_FULL);
    end
  endgenerate

  assign req_o.single = want_single && !blk_q;
  assign req_o.burst  = want_burst  && !blk_q;

  // hold off after ack until the level moves away from its value at ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= 1'b0;
      snap_q <= LVL_EMPTY;
    end else if (ack_i && (req_o.single || req_o.burst)) begin
      blk_q  <= 1'b1;
      snap_q <= level_i;
    end else if (blk_q && level_i != snap_q) begin
      blk_q  <= 1'b0;
    end
  end

  assert_req_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (req_o.single || req_o.burst)) |=> !(req_o.single || req_o.burst));
endmodule

// File: rtl/sbd_dma_req.sv
module sbd_dma_req
  import sbd_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned BW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          use_bursts_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic          bus_dual_i,
  input  logic [BW-1:0] bus_wdata_i,
  output logic [BW-1:0] bus_rdata_o,
  input  logic          shf_tx_pop_i,
  output logic [DW-1:0] shf_tx_data_o,
  input  logic          shf_rx_push_i,
  input  logic [DW-1:0] shf_rx_data_i,
  output logic [1:0]    tx_level_o,
  output logic [1:0]    rx_level_o,
  output logic          tx_single_o,
  output logic          tx_burst_o,
  input  logic          tx_ack_i,
  output logic          rx_single_o,
  output logic          rx_burst_o,
  input  logic          rx_ack_i,
  output logic          err_tx_udf_o,
  output logic          err_tx_ovf_o,
  output logic          err_rx_ovf_o
);
  lvl_t tx_lvl, rx_lvl, tx_lvl_ap, rx_lvl_ap;
  logic [BW-1:0] tx_dout, rx_dout, rx_din;
  logic tx_pop_ok, tx_wr_one, tx_wr_two;
  logic rd_one, rd_two, rx_push_ok;
  logic udf_q, tovf_q, rovf_q;
  req_t tx_req, rx_req;

  // transmit side
  assign tx_pop_ok = shf_tx_pop_i && (tx_lvl != LVL_EMPTY);
  assign tx_lvl_ap = tx_lvl - {1'b0, tx_pop_ok};
  assign tx_wr_one = bus_we_i && !bus_dual_i && (tx_lvl_ap != LVL_FULL);
  assign tx_wr_two = bus_we_i &&  bus_dual_i && (tx_lvl == LVL_EMPTY);

  sbd_pair_fifo #(.DW(DW)) u_tx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i ({tx_wr_two, tx_wr_one}),
    .din_i    (bus_wdata_i),
    .pop_n_i  ({1'b0, tx_pop_ok}),
    .level_o  (tx_lvl),
    .dout_o   (tx_dout)
  );

  // receive side
  assign rd_two     = bus_re_i &&  bus_dual_i && (rx_lvl == LVL_FULL);
  assign rd_one     = bus_re_i && !bus_dual_i && (rx_lvl != LVL_EMPTY);
  assign rx_lvl_ap  = rd_two ? LVL_EMPTY : (rx_lvl - {1'b0, rd_one});
  assign rx_push_ok = shf_rx_push_i && (rx_lvl_ap != LVL_FULL);
  assign rx_din     = {{DW{1'b0}}, shf_rx_data_i};

  sbd_pair_fifo #(.DW(DW)) u_rx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i ({1'b0, rx_push_ok}),
    .din_i    (rx_din),
    .pop_n_i  ({rd_two, rd_one}),
    .level_o  (rx_lvl),
    .dout_o   (rx_dout)
  );

  always_comb begin
    if (rd_two)      bus_rdata_o = rx_dout;
    else if (rd_one) bus_rdata_o = {{DW{1'b0}}, rx_dout[DW-1:0]};
    else             bus_rdata_o = '0;
  end

  // sticky error flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      udf_q  <= 1'b0;
      tovf_q <= 1'b0;
      rovf_q <= 1'b0;
    end else begin
      if (shf_tx_pop_i && !tx_pop_ok)                 udf_q  <= 1'b1;
      if (bus_we_i && !(tx_wr_one || tx_wr_two))      tovf_q <= 1'b1;
      if (shf_rx_push_i && !rx_push_ok)               rovf_q <= 1'b1;
    end
  end

  sbd_req_gen #(.IS_TX(1'b1)) u_tx_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .use_bursts_i (use_bursts_i),
    .level_i      (tx_lvl),
    .ack_i        (tx_ack_i),
    .req_o        (tx_req)
  );

  sbd_req_gen #(.IS_TX(1'b0)) u_rx_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .use_bursts_i (use_bursts_i),
    .level_i      (rx_lvl),
    .ack_i        (rx_ack_i),
    .req_o        (rx_req)
  );

  assign tx_single_o   = tx_req.single;
  assign tx_burst_o    = tx_req.burst;
  assign rx_single_o   = rx_req.single;
  assign rx_burst_o    = rx_req.burst;
  assign tx_level_o    = tx_lvl;
  assign rx_level_o    = rx_lvl;
  assign shf_tx_data_o = tx_dout[DW-1:0];
  assign err_tx_udf_o  = udf_q;
  assign err_tx_ovf_o  = tovf_q;
  assign err_rx_ovf_o  = rovf_q;

  assert_dual_wr_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_dual_i && tx_lvl == LVL_EMPTY) |=> tx_lvl == LVL_FULL);
  assert_dual_wr_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_dual_i && tx_lvl != LVL_EMPTY && !shf_tx_pop_i)
      |=> (err_tx_ovf_o && tx_lvl == $past(tx_lvl)));
  assert_dual_rd_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_dual_i && rx_lvl == LVL_FULL && !shf_rx_push_i) |=> rx_lvl == LVL_EMPTY);
  assert_underflow_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shf_tx_pop_i && tx_lvl == LVL_EMPTY) |=> err_tx_udf_o);
  assert_rx_ovf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rx_ovf_o |=> err_rx_ovf_o);
endmodule

// File: tb/sbd_dma_req_bench.sv
`timescale 1ns/1ps
module sbd_dma_req_bench;
  localparam int unsigned DW = 4;
  localparam int unsigned BW = 2 * DW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic use_bursts = 1'b0, we = 1'b0, re = 1'b0, dual = 1'b0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic tx_pop = 1'b0, rx_push = 1'b0;
  logic [DW-1:0] tx_data, rx_data = '0;
  logic [1:0] tx_lvl, rx_lvl;
  logic tx_single, tx_burst, rx_single, rx_burst;
  logic tx_ack = 1'b0, rx_ack = 1'b0;
  logic udf, tovf, rovf;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  sbd_dma_req #(.DW(DW)) u_sbd_dma_req (
    .clk_i(clk), .rst_ni(rst_ni), .use_bursts_i(use_bursts),
    .bus_we_i(we), .bus_re_i(re), .bus_dual_i(dual),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .shf_tx_pop_i(tx_pop), .shf_tx_data_o(tx_data),
    .shf_rx_push_i(rx_push), .shf_rx_data_i(rx_data),
    .tx_level_o(tx_lvl), .rx_level_o(rx_lvl),
    .tx_single_o(tx_single), .tx_burst_o(tx_burst), .tx_ack_i(tx_ack),
    .rx_single_o(rx_single), .rx_burst_o(rx_burst), .rx_ack_i(rx_ack),
    .err_tx_udf_o(udf), .err_tx_ovf_o(tovf), .err_rx_ovf_o(rovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    we = 0; re = 0; dual = 0; tx_pop = 0; rx_push = 0; tx_ack = 0; rx_ack = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    step();
    rst_ni = 1;
    step();
  endtask

  task automatic wr1(input logic [DW-1:0] v);
    we = 1; wdata = {{DW{1'b0}}, v}; step();
  endtask

  task automatic push(input logic [DW-1:0] v);
    rx_push = 1; rx_data = v; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // reset state
    chk("R13 reset tx level", tx_lvl, 0);
    chk("R13 reset rx level", rx_lvl, 0);
    chk("R1 reset tx_single", tx_single, 1);
    chk("R2 reset rx_single", rx_single, 0);
    chk("R10 reset udf", udf, 0);
    chk("R7 reset tovf", tovf, 0);
    chk("R11 reset rovf", rovf, 0);

    // R1 R2 R3 R4 R12: mode x level sweep
    for (int m = 0; m < 2; m++)
      for (int tl = 0; tl < 3; tl++)
        for (int rl = 0; rl < 3; rl++) begin
          use_bursts = m[0];
          do_reset();
          for (int k = 0; k < tl; k++) wr1(4'(k));
          for (int k = 0; k < rl; k++) push(4'(k));
          chk("R1 tx_single", tx_single, int'(m == 0 && tl < 2));
          chk("R3 tx_burst",  tx_burst,  int'(m == 1 && tl == 0));
          chk("R2 rx_single", rx_single, int'(m == 0 && rl > 0));
          chk("R4 rx_burst",  rx_burst,  int'(m == 1 && rl == 2));
          chk("R12 levels", tx_lvl * 4 + rx_lvl, tl * 4 + rl);
        end
    use_bursts = 0;

    // R6 R13: dual write then two pops for every combined word
    do_reset();
    for (int w = 0; w < 256; w++) begin
      we = 1; dual = 1; wdata = 8'(w); step();
      chk("R6 dual write level", tx_lvl, 2);
      chk("R6 entry0 low half", tx_data, w % 16);
      tx_pop = 1; step();
      chk("R13 entry1 second", tx_data, w / 16);
      tx_pop = 1; step();
      chk("R13 empty after pops", tx_lvl, 0);
    end

    // R8: two pushes then dual read for every combined word
    for (int w = 0; w < 256; w++) begin
      push(4'(w % 16));
      push(4'(w / 16));
      re = 1; dual = 1; #1;
      chk("R8 dual read word", rdata, w);
      step();
      chk("R8 dual read empties", rx_lvl, 0);
    end

    // R7: rejected writes
    do_reset();
    wr1(4'd5);
    we = 1; dual = 1; wdata = 8'hAB; step();
    chk("R7 dual reject level", tx_lvl, 1);
    chk("R7 dual reject head", tx_data, 5);
    chk("R7 dual reject flag", tovf, 1);
    do_reset();
    wr1(4'd1); wr1(4'd2);
    chk("R7 no flag before", tovf, 0);
    wr1(4'd3);
    chk("R7 full single reject flag", tovf, 1);
    chk("R7 full single level", tx_lvl, 2);
    chk("R7 full single head", tx_data, 1);

    // R9: single reads and short dual read
    do_reset();
    re = 1; #1;
    chk("R9 empty single read", rdata, 0);
    step();
    push(4'd3); push(4'd9);
    re = 1; #1;
    chk("R9 single read oldest", rdata, 3);
    step();
    chk("R9 single read pops", rx_lvl, 1);
    re = 1; dual = 1; #1;
    chk("R8 short dual read data", rdata, 0);
    step();
    chk("R8 short dual read level", rx_lvl, 1);
    re = 1; #1;
    chk("R9 next entry", rdata, 9);
    step();

    // R10: underflow sticky
    do_reset();
    tx_pop = 1; step();
    chk("R10 underflow set", udf, 1);
    wr1(4'd7); step(); step();
    chk("R10 underflow sticky", udf, 1);
    chk("R10 write after udf", tx_lvl, 1);

    // R11: rx overflow
    do_reset();
    push(4'd1); push(4'd2);
    chk("R11 no flag at full", rovf, 0);
    push(4'd3);
    chk("R11 overflow set", rovf, 1);
    chk("R11 level held", rx_lvl, 2);
    re = 1; dual = 1; #1;
    chk("R11 data kept", rdata, 8'h21);
    step(); step();
    chk("R11 overflow sticky", rovf, 1);

    // R5: ack hold-off, single mode tx
    do_reset();
    chk("R5 tx req before ack", tx_single, 1);
    tx_ack = 1; step();
    chk("R5 tx drop after ack", tx_single, 0);
    step(); step();
    chk("R5 tx held low", tx_single, 0);
    wr1(4'd4);
    chk("R5 tx low in cycle after change", tx_single, 0);
    step();
    chk("R5 tx reasserts", tx_single, 1);
    // ack together with write
    tx_ack = 1; we = 1; wdata = 8'd6; step();
    chk("R5 ack+write level", tx_lvl, 2);
    chk("R1 full drops single", tx_single, 0);
    tx_pop = 1; step();
    chk("R5 after pop level", tx_lvl, 1);
    step();
    chk("R5 reassert after pop", tx_single, 1);

    // R5: burst mode rx
    use_bursts = 1;
    do_reset();
    push(4'd1); push(4'd2);
    chk("R4 rx burst at full", rx_burst, 1);
    chk("R3 tx burst at empty", tx_burst, 1);
    rx_ack = 1; step();
    chk("R5 rx burst drop", rx_burst, 0);
    chk("R12 tx burst unaffected", tx_burst, 1);
    re = 1; dual = 1; step();
    push(4'd3); push(4'd4);
    step();
    chk("R5 rx burst back", rx_burst, 1);
    use_bursts = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule